// File: doc/BRIEF.md
# Scanline Display Mode Sequencer

This block keeps the timing of a 160×144 scanline display. Each line lasts 456 dot ticks and has three phases: an object-table scan, a pixel-transfer phase and a horizontal blank. After 144 visible lines come ten vertical-blank lines, so a frame is 154 lines long. The block reports the current phase and line number to the rest of the display pipeline. It gives the line renderer a one-cycle strobe when a line finishes. It also raises the single-cycle vertical-blank and status interrupt requests that the processor side needs.

A dot-clock enable (`dot_en`) advances the sequence by one dot. While the display-enable input is low, the sequencer parks: line 0, phase 0, no interrupts. The status interrupt collects several sources: entry into horizontal blank, entry into vertical blank, entry into the object scan, and a line-compare match. Each source has its own enable bit. Sources that fire on the same clock produce one pulse.

Internally a five-state machine runs alongside a dot/line counter pair. The states are OFF, OAM_SCAN, XFER, HBLANK and VBLANK. Its transitions are: OFF→OAM_SCAN on the first dot tick after enabling; OAM_SCAN→XFER at dot 80; XFER→HBLANK at dot 252; HBLANK→OAM_SCAN at the wrap to dot 0 of a line below 144; HBLANK→VBLANK at the wrap into line 144; VBLANK→OAM_SCAN at the wrap back to line 0; any state→OFF when the display is disabled. OFF reports the same phase code as horizontal blank.

Top module: `lcd_mode_seq`

## Requirements
- R1: `mode` reports the phase with the codes 0 = horizontal blank, 1 = vertical blank, 2 = object scan, 3 = pixel transfer. In a visible line, dots 0–79 are object scan, dots 80–251 are pixel transfer and dots 252–455 are horizontal blank. All dots of lines 144–153 are vertical blank.
- R2: `ly` counts lines 0 to 153 and then wraps to 0. A full frame takes 456 × 154 = 70224 dot ticks, and after exactly one frame from enabling, `ly` is 0 and `mode` is 2.
- R3: On a clock where `dot_en` is low, `mode` and `ly` do not change.
- R4: Entering horizontal blank pulses `line_render` for one clock while `ly` still shows the line just drawn. It also raises `irq_stat` when `ie_hblank` is set. One frame contains 144 such pulses.
- R5: Entering vertical blank, with `ly` = 144, always pulses `irq_vblank` for one clock, once per frame. It also raises `irq_stat` when `ie_vblank` is set.
- R6: Entering object scan raises `irq_stat` when `ie_oam` is set. Entering pixel transfer never raises `irq_stat`.
- R7: `ly_match` is high while `ly` equals `lyc_cmp`. The compare value is sampled one clock earlier. A rising edge of `ly_match` raises `irq_stat` when `ie_lyc` is set. Status sources on the same clock give a single one-cycle pulse.
- R8: A clock with `disp_on` low forces `ly` = 0, `mode` = 0 and `ly_match`, `line_render`, `irq_vblank` and `irq_stat` low. The first dot tick after re-enabling enters object scan.
- R9: While reset is asserted and right after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Advances the sequence by one dot when high |
| disp_on | input | 1 | Display enable; low parks the sequencer |
| ie_hblank | input | 1 | Status interrupt enable for horizontal-blank entry |
| ie_vblank | input | 1 | Status interrupt enable for vertical-blank entry |
| ie_oam | input | 1 | Status interrupt enable for object-scan entry |
| ie_lyc | input | 1 | Status interrupt enable for the line-compare rise |
| lyc_cmp | input | 8 | Line compare value |
| mode | output | 2 | Current phase code |
| ly | output | 8 | Current line number |
| ly_match | output | 1 | Line equals compare value |
| line_render | output | 1 | One-cycle strobe at horizontal-blank entry |
| irq_vblank | output | 1 | One-cycle vertical-blank interrupt request |
| irq_stat | output | 1 | One-cycle status interrupt request |

## Verification
The bench runs a dot-accurate reference model one clock ahead of the design and compares every output on every clock. It covers the wrap from line 153 back to 0 and the step into line 144. A design with an off-by-one counter there would show a shifted `irq_vblank` or a frame whose length is not 70224. Stalls in `dot_en` and a disable in the middle of a frame are included: a design that counted on every clock, or that did not clear the counters, would drift from the model at once. The bench also targets status sources that coincide on one clock and a compare match that appears just as the display is re-enabled. A design that merged these sources wrongly would give doubled or missing `irq_stat` pulses.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_OAM    = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_OAM_SCAN = 3'd1,
        ST_XFER     = 3'd2,
        ST_HBLANK   = 3'd3,
        ST_VBLANK   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic hblank;
        logic vblank;
        logic oam;
    } mode_entry_t;

endpackage

// File: rtl/lcd_dot_line_ctr.sv
module lcd_dot_line_ctr #(
    parameter int DOTS_PER_LINE = 456,
    parameter int TOTAL_LINES   = 154,
    parameter int DOT_W         = 9,
    parameter int LY_W          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            step,
    output logic [DOT_W-1:0] dot_q,
    output logic [LY_W-1:0]  line_q,
    output logic [DOT_W-1:0] dot_nxt,
    output logic [LY_W-1:0]  line_nxt
);

    localparam logic [DOT_W-1:0] DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [LY_W-1:0]  LINE_LAST = LY_W'(TOTAL_LINES - 1);

    always_comb begin
        dot_nxt  = dot_q;
        line_nxt = line_q;
        if (!run) begin
            dot_nxt  = '0;
            line_nxt = '0;
        end else if (step) begin
            if (dot_q == DOT_LAST) begin
                dot_nxt  = '0;
                line_nxt = (line_q == LINE_LAST) ? '0 : line_q + LY_W'(1);
            end else begin
                dot_nxt = dot_q + DOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dot_q  <= '0;
            line_q <= '0;
        end else begin
            dot_q  <= dot_nxt;
            line_q <= line_nxt;
        end
    end

endmodule

// File: rtl/lcd_mode_fsm.sv
module lcd_mode_fsm
    import lcd_seq_pkg::*;
#(
    parameter int OAM_DOTS  = 80,
    parameter int XFER_DOTS = 172,
    parameter int VIS_LINES = 144,
    parameter int DOT_W     = 9,
    parameter int LY_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [DOT_W-1:0] dot_nxt,
    input  logic [LY_W-1:0]  line_nxt,
    output lcd_mode_e        mode,
    output mode_entry_t      entry
);

    localparam logic [DOT_W-1:0] XFER_START = DOT_W'(OAM_DOTS);
    localparam logic [DOT_W-1:0] HB_START   = DOT_W'(OAM_DOTS + XFER_DOTS);
    localparam logic [LY_W-1:0]  VB_LINE    = LY_W'(VIS_LINES);

    seq_state_e state_q, state_nxt;
    logic       line_wrap;

    assign line_wrap = step && (dot_nxt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state_q;
        if (!run) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:      if (step) state_nxt = ST_OAM_SCAN;
                ST_OAM_SCAN: if (step && dot_nxt == XFER_START) state_nxt = ST_XFER;
                ST_XFER:     if (step && dot_nxt == HB_START) state_nxt = ST_HBLANK;
                ST_HBLANK:   if (line_wrap)
                                 state_nxt = (line_nxt == VB_LINE) ? ST_VBLANK : ST_OAM_SCAN;
                ST_VBLANK:   if (line_wrap && line_nxt == '0) state_nxt = ST_OAM_SCAN;
                default:     state_nxt = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_OAM_SCAN: mode = MODE_OAM;
            ST_XFER:     mode = MODE_XFER;
            ST_VBLANK:   mode = MODE_VBLANK;
            default:     mode = MODE_HBLANK;
        endcase
        entry.hblank = (state_nxt == ST_HBLANK)   && (state_q != ST_HBLANK);
        entry.vblank = (state_nxt == ST_VBLANK)   && (state_q != ST_VBLANK);
        entry.oam    = (state_nxt == ST_OAM_SCAN) && (state_q != ST_OAM_SCAN);
    end

endmodule

// File: rtl/lcd_irq_gen.sv
module lcd_irq_gen
    import lcd_seq_pkg::*;
#(
    parameter int LY_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  mode_entry_t     entry,
    input  logic            ie_hblank,
    input  logic            ie_vblank,
    input  logic            ie_oam,
    input  logic            ie_lyc,
    input  logic [LY_W-1:0] line_nxt,
    input  logic [LY_W-1:0] lyc_cmp,
    output logic            ly_match,
    output logic            line_render,
    output logic            irq_vblank,
    output logic            irq_stat
);

    logic match_nxt;
    logic match_rise;
    logic stat_any;

    always_comb begin
        match_nxt  = run && (line_nxt == lyc_cmp);
        match_rise = match_nxt && !ly_match;
        stat_any   = (entry.hblank && ie_hblank) ||
                     (entry.vblank && ie_vblank) ||
                     (entry.oam    && ie_oam)    ||
                     (match_rise   && ie_lyc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ly_match    <= 1'b0;
            line_render <= 1'b0;
            irq_vblank  <= 1'b0;
            irq_stat    <= 1'b0;
        end else begin
            ly_match    <= match_nxt;
            line_render <= run && entry.hblank;
            irq_vblank  <= run && entry.vblank;
            irq_stat    <= run && stat_any;
        end
    end

endmodule

// File: rtl/lcd_mode_seq.sv
module lcd_mode_seq
    import lcd_seq_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int OAM_DOTS      = 80,
    parameter int XFER_DOTS     = 172,
    parameter int VIS_LINES     = 144,
    parameter int TOTAL_LINES   = 154
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dot_en,
    input  logic       disp_on,
    input  logic       ie_hblank,
    input  logic       ie_vblank,
    input  logic       ie_oam,
    input  logic       ie_lyc,
    input  logic [7:0] lyc_cmp,
    output logic [1:0] mode,
    output logic [7:0] ly,
    output logic       ly_match,
    output logic       line_render,
    output logic       irq_vblank,
    output logic       irq_stat
);

    localparam int DOT_W = $clog2(DOTS_PER_LINE);
    localparam int LY_W  = 8;

    logic [DOT_W-1:0] dot_q, dot_nxt;
    logic [LY_W-1:0]  line_q, line_nxt;
    logic             step;
    lcd_mode_e        mode_w;
    mode_entry_t      entry_w;

    assign step = dot_en && disp_on;

    lcd_dot_line_ctr #(
        .DOTS_PER_LINE(DOTS_PER_LINE),
        .TOTAL_LINES  (TOTAL_LINES),
        .DOT_W        (DOT_W),
        .LY_W         (LY_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (disp_on),
        .step    (step),
        .dot_q   (dot_q),
        .line_q  (line_q),
        .dot_nxt (dot_nxt),
        .line_nxt(line_nxt)
    );

    lcd_mode_fsm #(
        .OAM_DOTS (OAM_DOTS),
        .XFER_DOTS(XFER_DOTS),
        .VIS_LINES(VIS_LINES),
        .DOT_W    (DOT_W),
        .LY_W     (LY_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (disp_on),
        .step    (step),
        .dot_nxt (dot_nxt),
        .line_nxt(line_nxt),
        .mode    (mode_w),
        .entry   (entry_w)
    );

    lcd_irq_gen #(
        .LY_W(LY_W)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (disp_on),
        .entry      (entry_w),
        .ie_hblank  (ie_hblank),
        .ie_vblank  (ie_vblank),
        .ie_oam     (ie_oam),
        .ie_lyc     (ie_lyc),
        .line_nxt   (line_nxt),
        .lyc_cmp    (lyc_cmp),
        .ly_match   (ly_match),
        .line_render(line_render),
        .irq_vblank (irq_vblank),
        .irq_stat   (irq_stat)
    );

    assign mode = mode_w;
    assign ly   = line_q;

    // dot_q is kept for completeness of the counter; only its next value is consumed
    logic unused_dot;
    assign unused_dot = ^dot_q;

endmodule

// File: rtl/lcd_mode_seq_chk.sv
module lcd_mode_seq_chk #(
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dot_en,
    input logic       disp_on,
    input logic [7:0] lyc_cmp,
    input logic [1:0] mode,
    input logic [7:0] ly,
    input logic       ly_match,
    input logic       line_render,
    input logic       irq_vblank,
    input logic       irq_stat
);

    localparam logic [7:0] LAST_LY = 8'(TOTAL_LINES - 1);
    localparam logic [7:0] VB_LY   = 8'(VIS_LINES);

    assert_ly_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ly <= LAST_LY);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && !dot_en) |=> ($stable(mode) && $stable(ly)));

    assert_render_in_hblank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_render |-> (mode == 2'd0 && ly < VB_LY));

    assert_vblank_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |-> (mode == 2'd1 && ly == VB_LY));

    assert_vblank_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |=> !irq_vblank);

    assert_xfer_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) != 2'd3 && !(ly_match && !$past(ly_match))) |-> !irq_stat);

    assert_match_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ly_match |-> (ly == $past(lyc_cmp)));

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> (ly == 8'd0 && mode == 2'd0 && !ly_match && !line_render && !irq_vblank && !irq_stat));

endmodule

bind lcd_mode_seq lcd_mode_seq_chk #(
    .VIS_LINES  (VIS_LINES),
    .TOTAL_LINES(TOTAL_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot_en     (dot_en),
    .disp_on    (disp_on),
    .lyc_cmp    (lyc_cmp),
    .mode       (mode),
    .ly         (ly),
    .ly_match   (ly_match),
    .line_render(line_render),
    .irq_vblank (irq_vblank),
    .irq_stat   (irq_stat)
);

// File: tb/lcd_mode_seq_bench.sv
`timescale 1ns/1ps
module lcd_mode_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dot_en = 1'b0;
    logic       disp_on = 1'b0;
    logic       ie_hblank = 1'b0, ie_vblank = 1'b0, ie_oam = 1'b0, ie_lyc = 1'b0;
    logic [7:0] lyc_cmp = 8'd0;
    logic [1:0] mode;
    logic [7:0] ly;
    logic       ly_match, line_render, irq_vblank, irq_stat;

    always #4 clk = ~clk;

    lcd_mode_seq u_lcd_mode_seq (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .disp_on(disp_on),
        .ie_hblank(ie_hblank), .ie_vblank(ie_vblank), .ie_oam(ie_oam), .ie_lyc(ie_lyc),
        .lyc_cmp(lyc_cmp), .mode(mode), .ly(ly), .ly_match(ly_match),
        .line_render(line_render), .irq_vblank(irq_vblank), .irq_stat(irq_stat)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] ly;
        logic       match;
        logic       render;
        logic       vb;
        logic       stat;
    } exp_t;

    exp_t exp_q[$];

    int n_tests = 0;
    int n_fail  = 0;
    int n_render = 0, n_vb = 0, n_stat = 0;

    // pending configuration, applied by the driver at its edge
    logic       c_ie_hb = 0, c_ie_vb = 0, c_ie_oam = 0, c_ie_lyc = 0;
    logic [7:0] c_lyc = 0;

    // reference model state
    int         m_dot = 0, m_line = 0;
    logic [1:0] m_mode = 2'd0;
    logic       m_match = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] mode_of(input int d, input int l);
        if (l >= 144) return 2'd1;
        if (d < 80)   return 2'd2;
        if (d < 252)  return 2'd3;
        return 2'd0;
    endfunction

    // driver: applies inputs for the next edge and pushes the expected result
    task automatic drive_cycle(input bit en, input bit on);
        exp_t       e;
        logic [1:0] mn;
        logic       mt;
        @(negedge clk);
        dot_en = en; disp_on = on;
        ie_hblank = c_ie_hb; ie_vblank = c_ie_vb; ie_oam = c_ie_oam; ie_lyc = c_ie_lyc;
        lyc_cmp = c_lyc;
        e = '0;
        if (!on) begin
            m_dot = 0; m_line = 0; mn = 2'd0; mt = 1'b0;
        end else begin
            if (en) begin
                if (m_dot == 455) begin
                    m_dot = 0;
                    m_line = (m_line == 153) ? 0 : m_line + 1;
                end else begin
                    m_dot++;
                end
                mn = mode_of(m_dot, m_line);
            end else begin
                mn = m_mode;
            end
            mt = (m_line == int'(c_lyc));
            if (mn != m_mode) begin
                case (mn)
                    2'd0: begin e.render = 1'b1; if (c_ie_hb) e.stat = 1'b1; end
                    2'd1: begin e.vb = 1'b1;     if (c_ie_vb) e.stat = 1'b1; end
                    2'd2: if (c_ie_oam) e.stat = 1'b1;
                    default: ;
                endcase
            end
            if (mt && !m_match && c_ie_lyc) e.stat = 1'b1;
        end
        m_mode = mn; m_match = mt;
        e.mode = mn; e.ly = 8'(m_line); e.match = mt;
        exp_q.push_back(e);
    endtask

    // monitor: pops one expectation per clock and compares all outputs
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R1 mode",        mode,        e.mode);
                chk("R2 ly",          ly,          e.ly);
                chk("R7 ly_match",    ly_match,    e.match);
                chk("R4 line_render", line_render, e.render);
                chk("R5 irq_vblank",  irq_vblank,  e.vb);
                chk("R6 irq_stat",    irq_stat,    e.stat);
                n_render += int'(line_render);
                n_vb     += int'(irq_vblank);
                n_stat   += int'(irq_stat);
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic set_ie(input bit hb, input bit vb, input bit oam, input bit lyc_en);
        c_ie_hb = hb; c_ie_vb = vb; c_ie_oam = oam; c_ie_lyc = lyc_en;
    endtask

    initial begin
        logic [1:0] s_mode;
        logic [7:0] s_ly;

        // R9: reset state
        repeat (4) @(negedge clk);
        chk("R9 mode in reset", mode, 0);
        chk("R9 ly in reset", ly, 0);
        chk("R9 pulses in reset", {ly_match, line_render, irq_vblank, irq_stat}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 mode after reset", mode, 0);
        chk("R9 outputs after reset", {ly, ly_match, line_render, irq_vblank, irq_stat}, 0);

        // enabled but no dot ticks: still parked in phase 0
        set_ie(1, 1, 1, 1); c_lyc = 8'd5;
        repeat (3) drive_cycle(0, 1);
        drive_cycle(0, 1);
        n_render = 0; n_vb = 0; n_stat = 0;

        // R2, R4, R5: one full frame
        for (int i = 0; i < 70224; i++) drive_cycle(1, 1);
        repeat (2) drive_cycle(0, 1);
        chk("R4 render strobes per frame", n_render, 144);
        chk("R5 vblank pulses per frame", n_vb, 1);
        chk("R2 ly after one frame", ly, 0);
        chk("R2 mode after one frame", mode, 2);

        // R3: stalls
        for (int i = 0; i < 100; i++) drive_cycle(1, 1);
        drive_cycle(0, 1);
        s_mode = mode; s_ly = ly;
        repeat (50) drive_cycle(0, 1);
        chk("R3 mode held while stalled", mode, s_mode);
        chk("R3 ly held while stalled", ly, s_ly);
        set_ie(1, 0, 0, 0);
        for (int i = 0; i < 3000; i++) drive_cycle((i % 3) == 0, 1);

        // R7: line compare rise
        set_ie(0, 0, 0, 1); c_lyc = 8'(m_line + 1);
        drive_cycle(0, 1);
        n_stat = 0;
        for (int i = 0; i < 456; i++) drive_cycle(1, 1);
        drive_cycle(0, 1);
        chk("R7 compare interrupts over a line", n_stat, 1);
        chk("R7 ly_match at port", ly_match, 1);

        // R6: object scan entry only; pixel transfer entry silent
        set_ie(0, 0, 1, 0); c_lyc = 8'd200;
        drive_cycle(0, 1);
        n_stat = 0;
        for (int i = 0; i < 456; i++) drive_cycle(1, 1);
        drive_cycle(0, 1);
        chk("R6 object scan interrupts over a line", n_stat, 1);
        set_ie(0, 0, 0, 0);
        n_stat = 0;
        for (int i = 0; i < 456; i++) drive_cycle(1, 1);
        drive_cycle(0, 1);
        chk("R6 no status without enables", n_stat, 0);

        // R8: disable mid-frame, then re-enable with a compare hit on line 0
        set_ie(1, 1, 1, 1); c_lyc = 8'd0;
        n_stat = 0; n_vb = 0; n_render = 0;
        for (int i = 0; i < 20; i++) drive_cycle(1, 0);
        drive_cycle(0, 0);
        chk("R8 ly while disabled", ly, 0);
        chk("R8 mode while disabled", mode, 0);
        chk("R8 pulses while disabled", n_stat + n_vb + n_render, 0);
        drive_cycle(0, 1);
        drive_cycle(0, 1);
        chk("R7 match after enable", ly_match, 1);
        chk("R7 single compare pulse after enable", n_stat, 1);
        drive_cycle(1, 1);
        drive_cycle(0, 1);
        chk("R8 first tick enters object scan", mode, 2);
        for (int i = 0; i < 600; i++) drive_cycle(1, 1);
        repeat (2) drive_cycle(0, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule